// File: doc/BRIEF.md
# Precision-Time Event Timestamp Latch

This block keeps one 64-bit timestamp for a single packet direction (receive or transmit). A packet parser upstream raises a one-cycle event strobe for each timing packet it finds. With the strobe it gives a 3-bit class mask saying which capture classes the packet belongs to, and a 16-bit sequence identifier. If the class mask overlaps the enabled classes and the slot is empty, the block copies the free-running time input and the sequence identifier into the slot. It then marks the slot as full.

Software polls a status word until the full flag is set. It then reads the timestamp as a low word and a high word and joins them into one 64-bit value. To re-arm the slot it writes a 1 to the full flag. Until that write, the slot is locked and every further event is dropped, so the held time cannot be overwritten before software has collected it. Software sets the enabled classes through a 3-bit field. A value of 0 turns capture off and 7 accepts every class. Software also writes the flag bit to discard stale captures whenever it changes the configuration.

Top module: `ts_capture_buf`

## Requirements
- R1: When an event strobe arrives, its class mask ANDed with the enable field is nonzero and the slot is empty, the next cycle shows status bit 16 set, status bits 15:0 equal to the event's sequence identifier, register 1 equal to bits 31:0 of the time input in the event cycle, and register 2 equal to bits 63:32 of that time.
- R2: An event whose class mask has no bit in common with the enable field (this includes any event while the field is 0) changes no register.
- R3: While status bit 16 is set, events are ignored, and the sequence identifier and both timestamp words keep their values.
- R4: A write to register 0 with bit 16 set clears the flag on the next cycle and keeps the stored sequence identifier and timestamp. The next qualifying event is then captured. An event that arrives in the same cycle as this write, while the flag is still set, is dropped.
- R5: A write to register 0 with bit 16 clear has no effect.
- R6: The read data follows the address in the same cycle. Register 0 reads as {15 zeros, flag, sequence[15:0]}, register 1 as time[31:0], register 2 as time[63:32], and register 3 as {29 zeros, enable[2:0]}. A write to register 3 stores bits 2:0 of the write data.
- R7: After reset, all four registers read as zero.
- R8: A write to the enable field takes effect from the next cycle. An event in the same cycle as the write is judged against the old value. An enable value of 7 accepts an event of any class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_strobe | input | 1 | One-cycle flag: timing packet seen |
| ev_class | input | 3 | Class mask of the flagged packet |
| ev_seq | input | 16 | Sequence identifier of the flagged packet |
| time_now | input | 64 | Current time from the time counter |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 status, 1 time low, 2 time high, 3 enable) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
On every cycle the assertions check that a capture copies the time and sequence presented in the event cycle, and that a full slot holds steady until it is cleared. They also check that the clear write empties the slot and that events outside the enabled classes never fill it. Only the bench scenarios can show the register layout as software sees it, including the way the 64-bit time is split into two words. The bench scenarios also show that a write without the flag bit is harmless, that an enable change applies from the next cycle, and that the stored values survive a clear.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

    // Register select codes; software decodes these offsets.
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_TS_LO  = 2'd1,
        SEL_TS_HI  = 2'd2,
        SEL_ENABLE = 2'd3
    } reg_sel_e;

    // Position of the full flag in the status word.
    localparam int unsigned FLAG_BIT = 16;

endpackage

// File: rtl/ts_cap_ctrl.sv
// Holds the enable field and decodes the slot-clear write.
module ts_cap_ctrl
    import ts_cap_pkg::*;
#(
    parameter int unsigned CLS_W  = 3,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [CLS_W-1:0]  en_o,
    output logic              clr_o
);

    typedef struct packed {
        logic [CLS_W-1:0] en;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        st_d  = st_q;
        clr_o = 1'b0;
        if (wr_i) begin
            unique case (reg_sel_e'(addr_i))
                SEL_ENABLE: st_d.en = wdata_i[CLS_W-1:0];
                SEL_STATUS: clr_o   = wdata_i[FLAG_BIT];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;

    // R8: an enable write is visible from the following cycle
    a_r8_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 2'd3) |=> (en_o == $past(wdata_i[CLS_W-1:0])));

endmodule

// File: rtl/ts_cap_slot.sv
// Single capture slot: full flag, sequence identifier and timestamp.
module ts_cap_slot #(
    parameter int unsigned CLS_W = 3,
    parameter int unsigned SEQ_W = 16,
    parameter int unsigned TS_W  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_i,
    input  logic [CLS_W-1:0] cls_i,
    input  logic [SEQ_W-1:0] seq_i,
    input  logic [TS_W-1:0]  time_i,
    input  logic [CLS_W-1:0] en_i,
    input  logic             clr_i,
    output logic             full_o,
    output logic [SEQ_W-1:0] seq_o,
    output logic [TS_W-1:0]  ts_o
);

    typedef struct packed {
        logic             full;
        logic [SEQ_W-1:0] seq;
        logic [TS_W-1:0]  ts;
    } slot_st_t;

    slot_st_t st_d, st_q;
    logic     hit;
    logic     take;

    always_comb begin
        hit  = ev_i && (|(cls_i & en_i));
        take = hit && !st_q.full;
        st_d = st_q;
        if (take) begin
            st_d.full = 1'b1;
            st_d.seq  = seq_i;
            st_d.ts   = time_i;
        end else if (clr_i) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_o = st_q.full;
    assign seq_o  = st_q.seq;
    assign ts_o   = st_q.ts;

    // R1: a qualifying event into an empty slot stores the presented time
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && (|(cls_i & en_i)) && !full_o)
        |=> (full_o && ts_o == $past(time_i) && seq_o == $past(seq_i)));

    // R2: an event outside the enabled classes never fills an empty slot
    a_r2_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_o && !(ev_i && (|(cls_i & en_i)))) |=> !full_o);

    // R3: a full slot keeps its contents unless it is cleared
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !clr_i) |=> (full_o && $stable(ts_o) && $stable(seq_o)));

    // R4: clearing a full slot empties it and keeps the data
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && clr_i) |=> (!full_o && $stable(ts_o) && $stable(seq_o)));

endmodule

// File: rtl/ts_cap_rdmux.sv
// Read-data multiplexer for the four registers.
module ts_cap_rdmux
    import ts_cap_pkg::*;
#(
    parameter int unsigned CLS_W  = 3,
    parameter int unsigned SEQ_W  = 16,
    parameter int unsigned TS_W   = 64,
    parameter int unsigned WORD_W = 32
) (
    input  logic [1:0]        addr_i,
    input  logic              full_i,
    input  logic [SEQ_W-1:0]  seq_i,
    input  logic [TS_W-1:0]   ts_i,
    input  logic [CLS_W-1:0]  en_i,
    output logic [WORD_W-1:0] rdata_o
);

    always_comb begin
        rdata_o = '0;
        unique case (reg_sel_e'(addr_i))
            SEL_STATUS: begin
                rdata_o[SEQ_W-1:0] = seq_i;
                rdata_o[FLAG_BIT]  = full_i;
            end
            SEL_TS_LO:  rdata_o = ts_i[WORD_W-1:0];
            SEL_TS_HI:  rdata_o = ts_i[TS_W-1:WORD_W];
            SEL_ENABLE: rdata_o[CLS_W-1:0] = en_i;
            default:    ;
        endcase
    end

endmodule

// File: rtl/ts_capture_buf.sv
module ts_capture_buf #(
    parameter int unsigned CLS_W  = 3,
    parameter int unsigned SEQ_W  = 16,
    parameter int unsigned TS_W   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_strobe,
    input  logic [CLS_W-1:0] ev_class,
    input  logic [SEQ_W-1:0] ev_seq,
    input  logic [TS_W-1:0]  time_now,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata
);

    localparam int unsigned WORD_W = TS_W / 2;

    logic [CLS_W-1:0] en;
    logic             clr;
    logic             full;
    logic [SEQ_W-1:0] seq;
    logic [TS_W-1:0]  ts;

    ts_cap_ctrl #(.CLS_W(CLS_W), .WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .en_o(en), .clr_o(clr)
    );

    ts_cap_slot #(.CLS_W(CLS_W), .SEQ_W(SEQ_W), .TS_W(TS_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_strobe), .cls_i(ev_class),
        .seq_i(ev_seq), .time_i(time_now), .en_i(en), .clr_i(clr),
        .full_o(full), .seq_o(seq), .ts_o(ts)
    );

    ts_cap_rdmux #(.CLS_W(CLS_W), .SEQ_W(SEQ_W), .TS_W(TS_W), .WORD_W(WORD_W)) u_rdmux (
        .addr_i(reg_addr), .full_i(full), .seq_i(seq), .ts_i(ts),
        .en_i(en), .rdata_o(reg_rdata)
    );

endmodule

// File: tb/ts_capture_buf_tb.sv
module ts_capture_buf_tb;

    typedef struct {
        logic [1:0]  addr;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_strobe = 1'b0;
    logic [2:0]  ev_class = '0;
    logic [15:0] ev_seq = '0;
    logic [63:0] time_now = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    rd_item_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ts_capture_buf u_dut (
        .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .ev_class(ev_class),
        .ev_seq(ev_seq), .time_now(time_now), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic quiet();
        ev_strobe = 1'b0;
        reg_wr    = 1'b0;
    endtask

    // Read: drive the address and push the expected value for the monitor.
    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        @(negedge clk);
        quiet();
        reg_addr = a;
        it.addr = a; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        quiet();
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic ev(input logic [2:0] c, input logic [15:0] s, input logic [63:0] t);
        @(negedge clk);
        quiet();
        ev_strobe = 1'b1; ev_class = c; ev_seq = s; time_now = t;
    endtask

    // Write and event in the same cycle.
    task automatic wr_ev(input logic [1:0] a, input logic [31:0] d,
                         input logic [2:0] c, input logic [15:0] s, input logic [63:0] t);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        ev_strobe = 1'b1; ev_class = c; ev_seq = s; time_now = t;
    endtask

    // Monitor: compare read data shortly after the driving edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                rd_item_t it;
                it = exp_q.pop_front();
                checks++;
                if (reg_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=%0d actual=%08h expected=%08h",
                             it.tag, it.addr, reg_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7 reset state
        rd(2'd0, 32'h0, "R7 status");
        rd(2'd1, 32'h0, "R7 ts_lo");
        rd(2'd2, 32'h0, "R7 ts_hi");
        rd(2'd3, 32'h0, "R7 enable");
        // R2 enable zero blocks capture
        ev(3'b001, 16'h0042, 64'h1111_2222_3333_4444);
        rd(2'd0, 32'h0, "R2 enable zero");
        // R6 enable readback
        wr(2'd3, 32'hFFFF_FFF9);
        rd(2'd3, 32'h1, "R6 enable field");
        // R2 non-overlapping class
        ev(3'b010, 16'h0043, 64'h5);
        rd(2'd0, 32'h0, "R2 class miss");
        // R1 capture
        ev(3'b001, 16'h1234, 64'h0123_4567_89AB_CDEF);
        rd(2'd0, 32'h0001_1234, "R1 status");
        rd(2'd1, 32'h89AB_CDEF, "R1 ts_lo");
        rd(2'd2, 32'h0123_4567, "R1 ts_hi");
        // R3 held while full
        ev(3'b001, 16'h5555, 64'hAAAA_BBBB_CCCC_DDDD);
        rd(2'd0, 32'h0001_1234, "R3 status");
        rd(2'd1, 32'h89AB_CDEF, "R3 ts_lo");
        // R5 write without flag bit
        wr(2'd0, 32'h0000_FFFF);
        rd(2'd0, 32'h0001_1234, "R5 status");
        // R4 clear keeps data, then re-capture
        wr(2'd0, 32'h0001_0000);
        rd(2'd0, 32'h0000_1234, "R4 cleared status");
        rd(2'd2, 32'h0123_4567, "R4 ts kept");
        ev(3'b011, 16'hBEEF, 64'hFEDC_BA98_7654_3210);
        rd(2'd0, 32'h0001_BEEF, "R4 recapture status");
        rd(2'd1, 32'h7654_3210, "R4 recapture lo");
        rd(2'd2, 32'hFEDC_BA98, "R4 recapture hi");
        // R4 clear and event in the same cycle: event dropped
        wr_ev(2'd0, 32'h0001_0000, 3'b001, 16'h7777, 64'h99);
        rd(2'd0, 32'h0000_BEEF, "R4 same-cycle event dropped");
        // R8 event with enable write uses old enable
        wr_ev(2'd3, 32'h0, 3'b001, 16'h0A0A, 64'h0000_0001_0000_0002);
        rd(2'd0, 32'h0001_0A0A, "R8 old enable used");
        rd(2'd3, 32'h0, "R8 enable now zero");
        wr(2'd0, 32'h0001_0000);
        ev(3'b001, 16'h0B0B, 64'h3);
        rd(2'd0, 32'h0000_0A0A, "R8 new enable blocks");
        // R8 enable 7 accepts any class
        wr(2'd3, 32'h7);
        ev(3'b100, 16'h0C0C, 64'h0000_0007_0000_0008);
        rd(2'd0, 32'h0001_0C0C, "R8 all classes");
        rd(2'd2, 32'h0000_0007, "R8 all classes hi");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule